// File: doc/BRIEF.md
# GPIO Controller with Per-Pin Interrupts

This block is a memory-mapped general-purpose I/O controller for a parameterised number of pins, from 1 to 31. Software reaches it through a simple 32-bit register bus. On that bus it can choose which pins drive their pads, set or clear output bits without a read-modify-write, and read the synchronised pad levels. Each pad input passes through a two-flop synchroniser. The synchronised level feeds both the input register and the interrupt logic.

Each pin has five interrupt controls: an enable bit, a sensing-type bit, a polarity bit, a pending status bit and a mask bit. Together these give level-high, level-low, rising-edge and falling-edge triggers. Software can emulate a both-edge trigger by toggling the polarity bit after each event. All pins feed one interrupt request line. A build option inverts the sense of the direction register, so that a set bit makes its pin an input.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset, every register reads 0 except the input register. `padOut` is 0 and `irqOut` is 0. `padOutEn` is all zeros in the normal build and all ones in the inverted build.
- R2: Writing to word 0x0C sets each output latch bit whose data bit is 1. Writing to word 0x10 clears each output latch bit whose data bit is 1. Zero data bits leave their latch bits unchanged. `padOut` shows the latch one cycle after the write, and reading either word returns the latch.
- R3: The direction register at word 0x00 can be read and written. In the normal build, `padOutEn` equals this register one cycle after a write.
- R4: With `OE_INVERT` set, `padOutEn` is the bitwise inverse of the direction register, so a 1 in the register makes that pin an input.
- R5: A read of word 0x04 returns `padIn` as it was two clock edges earlier, through a two-flop synchroniser. Writes to word 0x04 have no effect.
- R6: The enable (0x14), type (0x18), polarity (0x1C) and mask (0x24) registers can be read and written. Only the low `PIN_COUNT` bits are stored, and all higher read bits are 0.
- R7: With type 0 and polarity 1, an enabled pin sets its pending bit (word 0x20) on a 0-to-1 change of its synchronised input. The bit is set on the third clock edge after the pad changes. A 1-to-0 change does not set it.
- R8: With type 0 and polarity 0, an enabled pin sets its pending bit on a 1-to-0 change of its synchronised input. This has the same latency as R7.
- R9: An edge-mode pending bit stays set until software writes a 1 to that bit of word 0x20. Writing a 0 to the bit has no effect. If a new edge arrives in the same cycle as a clearing write, the bit stays set.
- R10: With type 1, the pending bit follows the active level of the synchronised input while the pin is enabled. The active level is high for polarity 1 and low for polarity 0. Writes to word 0x20 do not affect a level-mode pending bit.
- R11: An edge on a disabled pin is not recorded. A level-mode pending bit drops to 0 one cycle after its pin is disabled. Writing 0 to all enable bits forces `irqOut` low from the next cycle.
- R12: `irqOut` is the OR over all pins of pending AND enable AND mask. Clearing a mask bit lowers `irqOut` but keeps the pending bit.
- R13: Reads of word 0x08 or of any word above 0x24 return 0, and writes to those words change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Bus access in this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 6 | Byte address; bits 5:2 select the word |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid in the same cycle as a read access |
| padIn | input | PIN_COUNT | Asynchronous pad levels |
| padOut | output | PIN_COUNT | Output latch driven to the pads |
| padOutEn | output | PIN_COUNT | Pad driver enable, 1 = drive |
| irqOut | output | 1 | Combined interrupt request |

## Verification
Each result has a fixed latency:
- Register readback is combinational in the cycle of the read.
- `padOut`, `padOutEn` and the register contents take one edge after a write.
- The input register takes two edges after a pad change.
- An edge or level pending bit, and `irqOut` with it, takes three edges after a pad change.
- A level-low pending bit takes one edge after its enable write.

The bench drives every input on the falling edge and counts rising edges from that point. It samples one edge early to confirm that the old value still holds, then samples again on the due edge. The mixed tests place a clearing write in the same cycle as a new edge to cover the case where the edge must win.

// File: rtl/gpio_irq_pkg.sv
`timescale 1ns/1ps
package gpio_irq_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 6;
  localparam int IDX_W  = ADDR_W - 2;

  // word indices (byte offset / 4)
  localparam logic [IDX_W-1:0] IDX_OE    = 4'd0;
  localparam logic [IDX_W-1:0] IDX_IN    = 4'd1;
  localparam logic [IDX_W-1:0] IDX_GAP   = 4'd2;
  localparam logic [IDX_W-1:0] IDX_SET   = 4'd3;
  localparam logic [IDX_W-1:0] IDX_CLR   = 4'd4;
  localparam logic [IDX_W-1:0] IDX_IEN   = 4'd5;
  localparam logic [IDX_W-1:0] IDX_ITYPE = 4'd6;
  localparam logic [IDX_W-1:0] IDX_IPOL  = 4'd7;
  localparam logic [IDX_W-1:0] IDX_IPEND = 4'd8;
  localparam logic [IDX_W-1:0] IDX_IMASK = 4'd9;

  typedef struct packed {
    logic             wrOe;
    logic             wrSet;
    logic             wrClr;
    logic             wrIen;
    logic             wrItype;
    logic             wrIpol;
    logic             wrIpend;
    logic             wrImask;
    logic             rdHit;
    logic [IDX_W-1:0] rdIdx;
  } busStrobe_t;
endpackage

// File: rtl/gpio_ctrl.sv
`timescale 1ns/1ps
module gpio_ctrl
  import gpio_irq_pkg::*;
(
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output busStrobe_t        strobe
);
  logic [IDX_W-1:0] wordIdx;
  logic             wrCyc;
  logic             rdCyc;
  logic             unusedLowAddr;

  assign wordIdx       = busAddr[ADDR_W-1:2];
  assign wrCyc         = busSel & busWrite;
  assign rdCyc         = busSel & ~busWrite;
  assign unusedLowAddr = ^busAddr[1:0];

  always_comb begin
    strobe       = '0;
    strobe.rdIdx = wordIdx;
    case (wordIdx)
      IDX_OE:    begin strobe.wrOe    = wrCyc; strobe.rdHit = rdCyc; end
      IDX_IN:    begin                         strobe.rdHit = rdCyc; end
      IDX_SET:   begin strobe.wrSet   = wrCyc; strobe.rdHit = rdCyc; end
      IDX_CLR:   begin strobe.wrClr   = wrCyc; strobe.rdHit = rdCyc; end
      IDX_IEN:   begin strobe.wrIen   = wrCyc; strobe.rdHit = rdCyc; end
      IDX_ITYPE: begin strobe.wrItype = wrCyc; strobe.rdHit = rdCyc; end
      IDX_IPOL:  begin strobe.wrIpol  = wrCyc; strobe.rdHit = rdCyc; end
      IDX_IPEND: begin strobe.wrIpend = wrCyc; strobe.rdHit = rdCyc; end
      IDX_IMASK: begin strobe.wrImask = wrCyc; strobe.rdHit = rdCyc; end
      default:   begin end
    endcase
  end
endmodule

// File: rtl/gpio_sync.sv
`timescale 1ns/1ps
module gpio_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stage[0] <= '0;
        else       stage[0] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stage[s] <= '0;
        else       stage[s] <= stage[s-1];
      end
    end
  end

  assign dout = stage[STAGES-1];
endmodule

// File: rtl/gpio_datapath.sv
`timescale 1ns/1ps
module gpio_datapath
  import gpio_irq_pkg::*;
#(
  parameter int PIN_COUNT   = 8,
  parameter bit OE_INVERT   = 1'b0,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  busStrobe_t           strobe,
  input  logic [DATA_W-1:0]    busWdata,
  output logic [DATA_W-1:0]    busRdata,
  input  logic [PIN_COUNT-1:0] padIn,
  output logic [PIN_COUNT-1:0] padOut,
  output logic [PIN_COUNT-1:0] padOutEn,
  output logic                 irqOut
);
  localparam int PAD_W = DATA_W - PIN_COUNT;

  logic [PIN_COUNT-1:0] pinWr;
  logic [PIN_COUNT-1:0] oeReg, outReg, ienReg, itypeReg, ipolReg, imaskReg, ipendReg;
  logic [PIN_COUNT-1:0] syncCur, syncPrev;
  logic [PIN_COUNT-1:0] riseVec, fallVec, pendNext;
  logic [PIN_COUNT-1:0] rdVal;
  logic                 unusedWdata;

  assign pinWr       = busWdata[PIN_COUNT-1:0];
  assign unusedWdata = ^busWdata[DATA_W-1:PIN_COUNT];

  gpio_sync #(.WIDTH(PIN_COUNT), .STAGES(SYNC_STAGES)) sync_i (
    .clk  (clk),
    .rstN (rstN),
    .din  (padIn),
    .dout (syncCur)
  );

  assign riseVec = syncCur & ~syncPrev;
  assign fallVec = ~syncCur & syncPrev;

  // per-pin pending update: level pins track, edge pins latch (set beats clear)
  for (genvar p = 0; p < PIN_COUNT; p++) begin : g_pin
    logic edgeHit, levelHit, clrHit;
    assign edgeHit  = ipolReg[p] ? riseVec[p] : fallVec[p];
    assign levelHit = (syncCur[p] == ipolReg[p]);
    assign clrHit   = strobe.wrIpend & pinWr[p];
    assign pendNext[p] = itypeReg[p]
                       ? (ienReg[p] & levelHit)
                       : ((ipendReg[p] & ~clrHit) | (ienReg[p] & edgeHit));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      oeReg    <= '0;
      outReg   <= '0;
      ienReg   <= '0;
      itypeReg <= '0;
      ipolReg  <= '0;
      imaskReg <= '0;
      ipendReg <= '0;
      syncPrev <= '0;
    end else begin
      syncPrev <= syncCur;
      ipendReg <= pendNext;
      if (strobe.wrOe)    oeReg    <= pinWr;
      if (strobe.wrIen)   ienReg   <= pinWr;
      if (strobe.wrItype) itypeReg <= pinWr;
      if (strobe.wrIpol)  ipolReg  <= pinWr;
      if (strobe.wrImask) imaskReg <= pinWr;
      if (strobe.wrSet)      outReg <= outReg | pinWr;
      else if (strobe.wrClr) outReg <= outReg & ~pinWr;
    end
  end

  always_comb begin
    rdVal = '0;
    if (strobe.rdHit) begin
      case (strobe.rdIdx)
        IDX_OE:    rdVal = oeReg;
        IDX_IN:    rdVal = syncCur;
        IDX_SET:   rdVal = outReg;
        IDX_CLR:   rdVal = outReg;
        IDX_IEN:   rdVal = ienReg;
        IDX_ITYPE: rdVal = itypeReg;
        IDX_IPOL:  rdVal = ipolReg;
        IDX_IPEND: rdVal = ipendReg;
        IDX_IMASK: rdVal = imaskReg;
        default:   rdVal = '0;
      endcase
    end
  end

  assign busRdata = {{PAD_W{1'b0}}, rdVal};
  assign padOut   = outReg;

  if (OE_INVERT) begin : g_oe_inv
    assign padOutEn = ~oeReg;
  end else begin : g_oe_norm
    assign padOutEn = oeReg;
  end

  assign irqOut = |(ipendReg & ienReg & imaskReg);
endmodule

// File: rtl/gpio_irq_ctrl.sv
`timescale 1ns/1ps
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int PIN_COUNT = 8,
  parameter bit OE_INVERT = 1'b0
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busSel,
  input  logic                 busWrite,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [DATA_W-1:0]    busWdata,
  output logic [DATA_W-1:0]    busRdata,
  input  logic [PIN_COUNT-1:0] padIn,
  output logic [PIN_COUNT-1:0] padOut,
  output logic [PIN_COUNT-1:0] padOutEn,
  output logic                 irqOut
);
  busStrobe_t strobe;

  gpio_ctrl ctrl_i (
    .busSel   (busSel),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .strobe   (strobe)
  );

  gpio_datapath #(
    .PIN_COUNT   (PIN_COUNT),
    .OE_INVERT   (OE_INVERT),
    .SYNC_STAGES (2)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .padIn    (padIn),
    .padOut   (padOut),
    .padOutEn (padOutEn),
    .irqOut   (irqOut)
  );
endmodule

// File: rtl/gpio_irq_checker.sv
`timescale 1ns/1ps
module gpio_irq_checker
  import gpio_irq_pkg::*;
#(
  parameter int PIN_COUNT = 8,
  parameter bit OE_INVERT = 1'b0
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 busSel,
  input logic                 busWrite,
  input logic [ADDR_W-1:0]    busAddr,
  input logic [DATA_W-1:0]    busWdata,
  input logic [DATA_W-1:0]    busRdata,
  input logic [PIN_COUNT-1:0] padIn,
  input logic [PIN_COUNT-1:0] padOut,
  input logic [PIN_COUNT-1:0] padOutEn,
  input logic                 irqOut
);
  logic [IDX_W-1:0]     idx;
  logic                 wrCyc, rdCyc, unmapped, settled;
  logic [1:0]           sinceRst;
  logic [PIN_COUNT-1:0] wLow;
  logic                 unusedChk;

  assign idx       = busAddr[ADDR_W-1:2];
  assign wrCyc     = busSel && busWrite;
  assign rdCyc     = busSel && !busWrite;
  assign unmapped  = (idx == IDX_GAP) || (idx > IDX_IMASK);
  assign wLow      = busWdata[PIN_COUNT-1:0];
  assign settled   = (sinceRst >= 2'd2);
  assign unusedChk = ^{busAddr[1:0], busWdata[DATA_W-1:PIN_COUNT]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 sinceRst <= '0;
    else if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
  end

  a_r2_set_drives_high: assert property (@(posedge clk) disable iff (!rstN)
    (wrCyc && idx == IDX_SET) |=> ((padOut & $past(wLow)) == $past(wLow)));

  a_r2_clear_drives_low: assert property (@(posedge clk) disable iff (!rstN)
    (wrCyc && idx == IDX_CLR) |=> ((padOut & $past(wLow)) == '0));

  // R3 and R4: direction write reaches padOutEn, inverted in the inverting build
  a_r3_oe_follows_write: assert property (@(posedge clk) disable iff (!rstN)
    (wrCyc && idx == IDX_OE) |=> (padOutEn == (OE_INVERT ? ~$past(wLow) : $past(wLow))));

  a_r5_input_two_edges: assert property (@(posedge clk) disable iff (!rstN)
    (settled && rdCyc && idx == IDX_IN) |-> (busRdata[PIN_COUNT-1:0] == $past(padIn, 2)));

  a_r6_upper_bits_zero: assert property (@(posedge clk) disable iff (!rstN)
    rdCyc |-> (busRdata[DATA_W-1:PIN_COUNT] == '0));

  a_r11_disable_silences: assert property (@(posedge clk) disable iff (!rstN)
    (wrCyc && idx == IDX_IEN && wLow == '0) |=> !irqOut);

  a_r12_mask_silences: assert property (@(posedge clk) disable iff (!rstN)
    (wrCyc && idx == IDX_IMASK && wLow == '0) |=> !irqOut);

  a_r13_unmapped_write_inert: assert property (@(posedge clk) disable iff (!rstN)
    (wrCyc && unmapped) |=> ($stable(padOut) && $stable(padOutEn)));

  a_r13_unmapped_read_zero: assert property (@(posedge clk) disable iff (!rstN)
    (rdCyc && unmapped) |-> (busRdata == '0));
endmodule

bind gpio_irq_ctrl gpio_irq_checker #(
  .PIN_COUNT (PIN_COUNT),
  .OE_INVERT (OE_INVERT)
) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .busSel   (busSel),
  .busWrite (busWrite),
  .busAddr  (busAddr),
  .busWdata (busWdata),
  .busRdata (busRdata),
  .padIn    (padIn),
  .padOut   (padOut),
  .padOutEn (padOutEn),
  .irqOut   (irqOut)
);

// File: tb/gpio_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module gpio_irq_ctrl_tb_top;
  localparam int PINS = 8;
  localparam logic [31:0] PMASK = 32'h0000_00FF;
  localparam logic [5:0] A_OE = 6'h00, A_IN = 6'h04, A_GAP = 6'h08, A_SET = 6'h0C,
    A_CLR = 6'h10, A_IEN = 6'h14, A_TYPE = 6'h18, A_POL = 6'h1C, A_PEND = 6'h20,
    A_MASK = 6'h24, A_HIGH = 6'h28;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busSel = 1'b0, busWrite = 1'b0;
  logic [5:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata, busRdataInv;
  logic [PINS-1:0] padIn = '0;
  logic [PINS-1:0] padOut, padOutEn, padOutInv, padOutEnInv;
  logic irqOut, irqInv;

  int checkCount = 0;
  int failCount = 0;

  // expected register contents
  logic [31:0] mOe = 0, mOut = 0, mIen = 0, mType = 0, mPol = 0, mMask = 0;

  always #2.5 clk = ~clk;

  gpio_irq_ctrl #(.PIN_COUNT(PINS), .OE_INVERT(1'b0)) dut_i (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .padIn(padIn), .padOut(padOut),
    .padOutEn(padOutEn), .irqOut(irqOut));

  gpio_irq_ctrl #(.PIN_COUNT(PINS), .OE_INVERT(1'b1)) dutInv_i (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdataInv), .padIn(padIn), .padOut(padOutInv),
    .padOutEn(padOutEnInv), .irqOut(irqInv));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic [31:0] setModel(input logic [31:0] cur, input logic [31:0] w);
    return (cur | w) & PMASK;
  endfunction

  function automatic logic [31:0] clrModel(input logic [31:0] cur, input logic [31:0] w);
    return cur & ~w & PMASK;
  endfunction

  function automatic logic [31:0] modelRead(input logic [5:0] a);
    case (a)
      A_OE: return mOe;
      A_SET, A_CLR: return mOut;
      A_IEN: return mIen;
      A_TYPE: return mType;
      A_POL: return mPol;
      A_MASK: return mMask;
      default: return 32'h0;
    endcase
  endfunction

  // called at a falling edge; returns at the next falling edge
  task automatic busWr(input logic [5:0] a, input logic [31:0] d);
    busSel = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0; busWdata = '0;
  endtask

  task automatic doWrite(input logic [5:0] a, input logic [31:0] d);
    busWr(a, d);
    case (a)
      A_OE: mOe = d & PMASK;
      A_SET: mOut = setModel(mOut, d);
      A_CLR: mOut = clrModel(mOut, d);
      A_IEN: mIen = d & PMASK;
      A_TYPE: mType = d & PMASK;
      A_POL: mPol = d & PMASK;
      A_MASK: mMask = d & PMASK;
      default: ;
    endcase
  endtask

  task automatic busRd(input logic [5:0] a, output logic [31:0] d);
    busSel = 1'b1; busWrite = 1'b0; busAddr = a;
    #1;
    d = busRdata;
    busSel = 1'b0;
  endtask

  task automatic expectReg(input string req, input logic [5:0] a, input logic [31:0] exp);
    logic [31:0] d;
    busRd(a, d);
    check(req, d, exp);
  endtask

  task automatic expectPend(input string req, input logic [31:0] bitSel, input logic [31:0] exp);
    logic [31:0] d;
    busRd(A_PEND, d);
    check(req, d & bitSel, exp & bitSel);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    failCount++;
    $display("FAIL watchdog all-requirements actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end

  initial begin : main
    logic [31:0] d;
    logic [5:0] wrAddrs [8];
    logic [5:0] rdAddrs [7];
    void'($urandom(32'h5EED_1234));
    wrAddrs = '{A_OE, A_SET, A_CLR, A_IEN, A_TYPE, A_POL, A_MASK, A_GAP};
    rdAddrs = '{A_OE, A_SET, A_CLR, A_IEN, A_TYPE, A_POL, A_MASK};

    tick(3);
    rstN = 1'b1;
    tick(1);

    // R1 reset state
    expectReg("R1 oe", A_OE, 0);
    expectReg("R1 out", A_SET, 0);
    expectReg("R1 ien", A_IEN, 0);
    expectReg("R1 type", A_TYPE, 0);
    expectReg("R1 pol", A_POL, 0);
    expectReg("R1 pend", A_PEND, 0);
    expectReg("R1 mask", A_MASK, 0);
    check("R1 padOut", {24'h0, padOut}, 0);
    check("R1 padOutEn", {24'h0, padOutEn}, 0);
    check("R1 padOutEn inverted build", {24'h0, padOutEnInv}, PMASK);
    check("R1 irqOut", {31'h0, irqOut}, 0);

    // R3 / R4 direction
    doWrite(A_OE, 32'h0000_005A);
    check("R3 padOutEn", {24'h0, padOutEn}, 32'h5A);
    check("R4 padOutEn inverted", {24'h0, padOutEnInv}, 32'hA5);
    expectReg("R3 oe readback", A_OE, 32'h5A);

    // R2 set / clear
    doWrite(A_SET, 32'h0000_000F);
    check("R2 set", {24'h0, padOut}, 32'h0F);
    doWrite(A_SET, 32'h0000_0030);
    check("R2 set keeps others", {24'h0, padOut}, 32'h3F);
    doWrite(A_CLR, 32'h0000_0005);
    check("R2 clear", {24'h0, padOut}, 32'h3A);
    doWrite(A_SET, 32'h0);
    check("R2 zero set no effect", {24'h0, padOut}, 32'h3A);
    expectReg("R2 latch readback at clear word", A_CLR, 32'h3A);

    // R6 width limit
    doWrite(A_IEN, 32'hFFFF_FFFF);
    expectReg("R6 upper bits zero", A_IEN, PMASK);
    doWrite(A_IEN, 32'h0);

    // R13 unmapped
    doWrite(A_GAP, 32'hFFFF_FFFF);
    expectReg("R13 gap read", A_GAP, 0);
    expectReg("R13 high read", A_HIGH, 0);
    busWr(6'h3C, 32'hFFFF_FFFF);
    check("R13 unmapped write padOut", {24'h0, padOut}, mOut);
    check("R13 unmapped write padOutEn", {24'h0, padOutEn}, mOe);

    // R5 input write ignored, latency two edges
    busWr(A_IN, 32'hFF);
    expectReg("R5 input write ignored", A_IN, 0);
    padIn = 8'hC3;
    tick(1);
    expectReg("R5 not yet after one edge", A_IN, 0);
    tick(1);
    expectReg("R5 sampled after two edges", A_IN, 32'hC3);
    padIn = '0;
    tick(3);

    // random register traffic (R2 R3 R4 R6 R13)
    for (int it = 0; it < 200; it++) begin
      logic [5:0] wa, ra;
      logic [31:0] wd;
      wa = wrAddrs[$urandom_range(0, 7)];
      ra = rdAddrs[$urandom_range(0, 6)];
      wd = $urandom();
      doWrite(wa, wd);
      expectReg("R6 random readback", ra, modelRead(ra));
      check("R2 random padOut", {24'h0, padOut}, mOut);
      check("R4 random inverted padOutEn", {24'h0, padOutEnInv}, ~mOe & PMASK);
    end

    // quiet the interrupt logic
    doWrite(A_IEN, 0);
    doWrite(A_MASK, 0);
    doWrite(A_TYPE, 0);
    doWrite(A_POL, 0);
    busWr(A_PEND, 32'hFF);
    expectReg("R9 all cleared", A_PEND, 0);

    // R7 rising edge on pin 1
    doWrite(A_POL, 32'h02);
    doWrite(A_MASK, 32'h02);
    doWrite(A_IEN, 32'h02);
    padIn[1] = 1'b1;
    tick(2);
    expectPend("R7 not yet after two edges", 32'h02, 0);
    tick(1);
    expectPend("R7 rising sets pending", 32'h02, 32'h02);
    check("R12 irq with enable and mask", {31'h0, irqOut}, 1);
    padIn[1] = 1'b0;
    tick(4);
    expectPend("R9 sticky after falling", 32'h02, 32'h02);
    busWr(A_PEND, 32'h0);
    expectPend("R9 zero write no effect", 32'h02, 32'h02);
    busWr(A_PEND, 32'h02);
    expectPend("R9 clear by write one", 32'h02, 0);
    check("R12 irq drops", {31'h0, irqOut}, 0);

    // R9 edge in the same cycle as clear wins
    padIn[1] = 1'b1;
    tick(3);
    padIn[1] = 1'b0;
    tick(4);
    padIn[1] = 1'b1;
    tick(2);
    busWr(A_PEND, 32'h02);
    expectPend("R9 new edge beats clear", 32'h02, 32'h02);
    busWr(A_PEND, 32'h02);
    padIn[1] = 1'b0;
    tick(4);
    expectPend("R7 falling ignored on rising pin", 32'h02, 0);

    // R8 falling edge on pin 2
    padIn[2] = 1'b1;
    tick(4);
    doWrite(A_IEN, 32'h06);
    doWrite(A_MASK, 32'h06);
    expectPend("R8 no capture on steady high", 32'h04, 0);
    padIn[2] = 1'b0;
    tick(2);
    expectPend("R8 not yet", 32'h04, 0);
    tick(1);
    expectPend("R8 falling sets pending", 32'h04, 32'h04);
    busWr(A_PEND, 32'h04);

    // R10 level high on pin 3
    doWrite(A_POL, mPol | 32'h08);
    doWrite(A_TYPE, 32'h08);
    doWrite(A_MASK, mMask | 32'h08);
    doWrite(A_IEN, mIen | 32'h08);
    padIn[3] = 1'b1;
    tick(2);
    expectPend("R10 level not yet", 32'h08, 0);
    tick(1);
    expectPend("R10 level high pending", 32'h08, 32'h08);
    busWr(A_PEND, 32'h08);
    expectPend("R10 write ignored on level pin", 32'h08, 32'h08);
    padIn[3] = 1'b0;
    tick(3);
    expectPend("R10 follows level low", 32'h08, 0);
    check("R12 irq low", {31'h0, irqOut}, 0);

    // R10 / R11 level low on pin 4
    doWrite(A_TYPE, mType | 32'h10);
    doWrite(A_MASK, mMask | 32'h10);
    doWrite(A_IEN, mIen | 32'h10);
    expectPend("R10 level low one edge after enable", 32'h10, 0);
    tick(1);
    expectPend("R10 level low pending", 32'h10, 32'h10);
    check("R12 irq from level low", {31'h0, irqOut}, 1);
    doWrite(A_IEN, mIen & ~32'h10);
    check("R11 irq gated by enable", {31'h0, irqOut}, 0);
    tick(1);
    expectPend("R11 level pending drops when disabled", 32'h10, 0);

    // R11 disabled edge pin 5
    doWrite(A_POL, mPol | 32'h20);
    doWrite(A_MASK, mMask | 32'h20);
    padIn[5] = 1'b1;
    tick(4);
    expectPend("R11 disabled edge not recorded", 32'h20, 0);
    doWrite(A_IEN, mIen | 32'h20);
    tick(1);
    expectPend("R11 no retroactive capture", 32'h20, 0);

    // R12 mask on pin 6
    doWrite(A_POL, mPol | 32'h40);
    doWrite(A_MASK, mMask & ~32'h40);
    doWrite(A_IEN, mIen | 32'h40);
    padIn[6] = 1'b1;
    tick(3);
    expectPend("R12 masked pending still set", 32'h40, 32'h40);
    check("R12 masked irq low", {31'h0, irqOut}, 0);
    doWrite(A_MASK, mMask | 32'h40);
    check("R12 unmask raises irq", {31'h0, irqOut}, 1);
    doWrite(A_MASK, 0);
    check("R12 mask lowers irq", {31'h0, irqOut}, 0);
    expectPend("R12 pending kept under mask", 32'h40, 32'h40);

    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end
endmodule